// File: doc/BRIEF.md
# Per-Thread Control State Store with Trap Redirect

This block holds the control state for a pool of hardware threads: one 64-bit status word for each thread and eight 64-bit branch-target registers beside it. The status word carries the thread's 32-bit program counter in its low half. The upper half packs a trap-disable mask, a byte of mode bits and a four-deep history of 4-bit condition codes. Each target register has the same layout as a status word. A branch target is loaded into a target register well ahead of the decision to branch. When the branch is taken, only the low 32 bits of that register become the new program counter.

One operation is applied per clock to the thread named by the operation's thread ID. The operations are: write a whole status word, set the program counter, load a target register, take a branch through a target register, push a condition code into the history, and raise a trap. A trap works as a coroutine call. The thread's status word and its target register 0 trade places, so the handler runs with the state that T0 held, and T0 keeps the interrupted state for a later resume. A trap whose cause is disabled in the thread's mask does nothing. A separate registered read port returns any thread's status word and any one of its target registers.

Top module: `thread_ctl_store`

## Requirements
- R1: After reset every status word and every target register of every thread reads as zero, and both read outputs are zero.
- R2: `rdStatus` and `rdTarget` show the contents selected by `rdTid`/`rdTidx` one clock after the address is presented. A write in the same cycle as the read returns the value from before the write.
- R3: Opcode 1 writes all 64 bits of `opData` to the status word of `opTid`. Opcode 3 writes `opData` to target register `opTidx` of `opTid`.
- R4: Opcode 2 replaces status bits [31:0] (the program counter) with `opData[31:0]` and leaves bits [63:32] unchanged.
- R5: Opcode 4 copies bits [31:0] of target register `opTidx` into status bits [31:0]. Status bits [63:32] and the target register are left unchanged.
- R6: Opcode 5 shifts the condition history in status bits [47:32] up by one 4-bit code. `opData[3:0]` enters at bits [35:32] and the code in bits [47:44] is dropped. All other status bits are unchanged.
- R7: Opcode 6, when status bit 56+`opCause` (the trap-disable mask is bits [63:56]) is clear, loads the old T0 into the status word and the old status word into T0 in the same cycle.
- R8: Opcode 6, when status bit 56+`opCause` is set, changes neither the status word nor any target register.
- R9: An operation changes only the state of thread `opTid`. Opcodes 0 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| opCode | input | 3 | Operation: 0 none, 1 write status, 2 set PC, 3 load target, 4 branch, 5 push condition code, 6 trap, 7 none |
| opTid | input | 7 | Thread the operation applies to |
| opTidx | input | 3 | Target register index for load and branch |
| opData | input | 64 | Write data, new PC (low 32 bits) or condition code (low 4 bits) |
| opCause | input | 3 | Trap cause, selects a bit of the disable mask |
| rdTid | input | 7 | Thread selected for reading |
| rdTidx | input | 3 | Target register selected for reading |
| rdStatus | output | 64 | Status word of the read thread, one cycle later |
| rdTarget | output | 64 | Selected target register of the read thread, one cycle later |

## Verification
The hardest state to reach from the ports is a trap whose cause bit is disabled in the mask of a status word that itself came out of an earlier trap swap. It is also hard to bring about a read of that same thread in the cycle the swap is taking place. The directed part builds this chain on one thread: load a handler into T0, trap to swap, write a mask, trap on a disabled cause, then trap on an enabled cause. Each step reads the thread in the same cycle. The random part confines thread IDs to four threads and draws random mask bytes, so status words that were swapped, masked and shifted meet reads of the same thread many times.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_WRSSW  = 3'd1,
    OP_SETPC  = 3'd2,
    OP_LDTGT  = 3'd3,
    OP_BRANCH = 3'd4,
    OP_PUSHCC = 3'd5,
    OP_TRAP   = 3'd6,
    OP_IDLE   = 3'd7
  } opcode_e;

  // One strobe per state change the datapath knows how to make.
  typedef struct packed {
    logic wrSsw;
    logic setPc;
    logic ldTgt;
    logic branch;
    logic pushCc;
    logic trapSwap;
  } strobes_t;

endpackage

// File: rtl/tcs_ctrl.sv
module tcs_ctrl
  import tcs_pkg::*;
#(
  parameter int MASKW = 8,
  localparam int CAUSEW = $clog2(MASKW)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        opCode,
  input  logic [CAUSEW-1:0] opCause,
  input  logic [MASKW-1:0]  trapMask,
  output strobes_t          stb
);

  opcode_e opKind;
  logic    causeEnabled;

  assign opKind       = opcode_e'(opCode);
  assign causeEnabled = ~trapMask[opCause];

  always_comb begin
    stb = '0;
    unique case (opKind)
      OP_WRSSW:  stb.wrSsw    = 1'b1;
      OP_SETPC:  stb.setPc    = 1'b1;
      OP_LDTGT:  stb.ldTgt    = 1'b1;
      OP_BRANCH: stb.branch   = 1'b1;
      OP_PUSHCC: stb.pushCc   = 1'b1;
      OP_TRAP:   stb.trapSwap = causeEnabled;
      default:   stb          = '0;
    endcase
  end

  // R9: no more than one kind of state change per cycle
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

  // R8: a trap on a disabled cause raises no strobe at all
  p_masked_trap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (opKind == OP_TRAP && trapMask[opCause]) |-> (stb == '0));

  // R9: idle opcodes raise no strobe
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (opKind == OP_NOP || opKind == OP_IDLE) |-> (stb == '0));

endmodule

// File: rtl/tcs_datapath.sv
module tcs_datapath
  import tcs_pkg::*;
#(
  parameter int THREADS = 128,
  parameter int NTGT    = 8,
  parameter int WORD    = 64,
  parameter int PCW     = 32,
  parameter int CCW     = 4,
  parameter int CCDEPTH = 4,
  parameter int MASKW   = 8,
  localparam int TIDW     = $clog2(THREADS),
  localparam int TIXW     = $clog2(NTGT),
  localparam int CCBITS   = CCW * CCDEPTH,
  localparam int CC_LSB   = PCW,
  localparam int MASK_LSB = WORD - MASKW
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         stb,
  input  logic [TIDW-1:0]  opTid,
  input  logic [TIXW-1:0]  opTidx,
  input  logic [WORD-1:0]  opData,
  input  logic [TIDW-1:0]  rdTid,
  input  logic [TIXW-1:0]  rdTidx,
  output logic [MASKW-1:0] trapMask,
  output logic [WORD-1:0]  rdStatus,
  output logic [WORD-1:0]  rdTarget
);

  logic [WORD-1:0] sswMem [THREADS];
  logic [WORD-1:0] tgtMem [THREADS][NTGT];

  logic [WORD-1:0]   curSsw;
  logic [WORD-1:0]   curT0;
  logic [PCW-1:0]    curTgtPc;
  logic [CCBITS-1:0] ccOld;
  logic [CCBITS-1:0] ccNew;
  logic [WORD-1:0]   nextSsw;
  logic              sswWe;

  assign curSsw   = sswMem[opTid];
  assign curT0    = tgtMem[opTid][0];
  assign curTgtPc = tgtMem[opTid][opTidx][PCW-1:0];
  assign trapMask = curSsw[MASK_LSB +: MASKW];

  // Condition history: newest code at the bottom, oldest falls off the top.
  assign ccOld = curSsw[CC_LSB +: CCBITS];
  assign ccNew = {ccOld[CCBITS-CCW-1:0], opData[CCW-1:0]};

  assign sswWe = stb.wrSsw | stb.setPc | stb.branch | stb.pushCc | stb.trapSwap;

  always_comb begin
    nextSsw = curSsw;
    if (stb.wrSsw)         nextSsw = opData;
    else if (stb.setPc)    nextSsw[PCW-1:0] = opData[PCW-1:0];
    else if (stb.branch)   nextSsw[PCW-1:0] = curTgtPc;
    else if (stb.pushCc)   nextSsw[CC_LSB +: CCBITS] = ccNew;
    else if (stb.trapSwap) nextSsw = curT0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdStatus <= '0;
      rdTarget <= '0;
      for (int t = 0; t < THREADS; t++) begin
        sswMem[t] <= '0;
        for (int k = 0; k < NTGT; k++) tgtMem[t][k] <= '0;
      end
    end else begin
      rdStatus <= sswMem[rdTid];
      rdTarget <= tgtMem[rdTid][rdTidx];
      if (sswWe)        sswMem[opTid]         <= nextSsw;
      if (stb.ldTgt)    tgtMem[opTid][opTidx] <= opData;
      if (stb.trapSwap) tgtMem[opTid][0]      <= curSsw;
    end
  end

  p_setpc_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.setPc |=> (sswMem[$past(opTid)] ==
                   {$past(curSsw[WORD-1:PCW]), $past(opData[PCW-1:0])}));

  p_branch_pc_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.branch |=> (sswMem[$past(opTid)] ==
                    {$past(curSsw[WORD-1:PCW]), $past(curTgtPc)}));

  p_cc_shift_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.pushCc |=> (sswMem[$past(opTid)][CC_LSB +: CCW] == $past(opData[CCW-1:0]))
               && (sswMem[$past(opTid)][CC_LSB+CCW +: CCBITS-CCW] ==
                   $past(curSsw[CC_LSB +: CCBITS-CCW])));

  p_trap_swap_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.trapSwap |=> (sswMem[$past(opTid)] == $past(curT0))
                 && (tgtMem[$past(opTid)][0] == $past(curSsw)));

endmodule

// File: rtl/thread_ctl_store.sv
module thread_ctl_store
  import tcs_pkg::*;
#(
  parameter int THREADS = 128,
  parameter int NTGT    = 8,
  parameter int WORD    = 64,
  parameter int PCW     = 32,
  parameter int CCW     = 4,
  parameter int CCDEPTH = 4,
  parameter int MASKW   = 8,
  localparam int TIDW   = $clog2(THREADS),
  localparam int TIXW   = $clog2(NTGT),
  localparam int CAUSEW = $clog2(MASKW)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        opCode,
  input  logic [TIDW-1:0]   opTid,
  input  logic [TIXW-1:0]   opTidx,
  input  logic [WORD-1:0]   opData,
  input  logic [CAUSEW-1:0] opCause,
  input  logic [TIDW-1:0]   rdTid,
  input  logic [TIXW-1:0]   rdTidx,
  output logic [WORD-1:0]   rdStatus,
  output logic [WORD-1:0]   rdTarget
);

  strobes_t         stb;
  logic [MASKW-1:0] trapMask;

  tcs_ctrl #(.MASKW(MASKW)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .opCode   (opCode),
    .opCause  (opCause),
    .trapMask (trapMask),
    .stb      (stb)
  );

  tcs_datapath #(
    .THREADS (THREADS),
    .NTGT    (NTGT),
    .WORD    (WORD),
    .PCW     (PCW),
    .CCW     (CCW),
    .CCDEPTH (CCDEPTH),
    .MASKW   (MASKW)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .opTid    (opTid),
    .opTidx   (opTidx),
    .opData   (opData),
    .rdTid    (rdTid),
    .rdTidx   (rdTidx),
    .trapMask (trapMask),
    .rdStatus (rdStatus),
    .rdTarget (rdTarget)
  );

  // R1: the cycle after reset is released, both read outputs are still zero
  p_reset_clear_r1: assert property (@(posedge clk)
    $rose(rstN) |-> (rdStatus == '0 && rdTarget == '0));

endmodule

// File: tb/tb_thread_ctl_store.sv
module tb_thread_ctl_store;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  opCode = 3'd0;
  logic [6:0]  opTid = '0;
  logic [2:0]  opTidx = '0;
  logic [63:0] opData = '0;
  logic [2:0]  opCause = '0;
  logic [6:0]  rdTid = '0;
  logic [2:0]  rdTidx = '0;
  logic [63:0] rdStatus;
  logic [63:0] rdTarget;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [63:0] mSsw [128];
  logic [63:0] mTgt [128][8];

  thread_ctl_store dut (
    .clk(clk), .rstN(rstN), .opCode(opCode), .opTid(opTid), .opTidx(opTidx),
    .opData(opData), .opCause(opCause), .rdTid(rdTid), .rdTidx(rdTidx),
    .rdStatus(rdStatus), .rdTarget(rdTarget)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference model of the requirements.
  task automatic applyModel(input int op, input int tid, input int tix,
                            input logic [63:0] d, input int cause);
    logic [63:0] s;
    s = mSsw[tid];
    case (op)
      1: mSsw[tid] = d;
      2: mSsw[tid] = {s[63:32], d[31:0]};
      3: mTgt[tid][tix] = d;
      4: mSsw[tid] = {s[63:32], mTgt[tid][tix][31:0]};
      5: mSsw[tid] = {s[63:48], s[43:32], d[3:0], s[31:0]};
      6: if (!s[56+cause]) begin
           mSsw[tid] = mTgt[tid][0];
           mTgt[tid][0] = s;
         end
      default: ;
    endcase
  endtask

  // Drive one operation and one read in the same cycle; the read must show pre-write state.
  task automatic step(input string tag, input int op, input int tid, input int tix,
                      input logic [63:0] d, input int cause, input int rt, input int rti);
    logic [63:0] expS, expT;
    @(negedge clk);
    opCode = 3'(op); opTid = 7'(tid); opTidx = 3'(tix); opData = d; opCause = 3'(cause);
    rdTid = 7'(rt); rdTidx = 3'(rti);
    expS = mSsw[rt];
    expT = mTgt[rt][rti];
    applyModel(op, tid, tix, d, cause);
    @(posedge clk);
    #1;
    check({tag, " status"}, rdStatus, expS);
    check({tag, " target"}, rdTarget, expT);
  endtask

  task automatic peek(input string tag, input int rt, input int rti);
    step(tag, 0, 0, 0, 64'd0, 0, rt, rti);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < 128; t++) begin
      mSsw[t] = '0;
      for (int k = 0; k < 8; k++) mTgt[t][k] = '0;
    end
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1;
    check("R1 rdStatus in reset", rdStatus, 64'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset contents
    peek("R1 thread5 T0", 5, 0);
    peek("R1 thread127 T7", 127, 7);

    // R3 with same-cycle read of old value (R2)
    step("R2 same-cycle wrssw", 1, 5, 0, 64'h00AB_0000_1234_5678, 0, 5, 0);
    peek("R3 wrssw", 5, 3);
    check("R3 wrssw literal", rdStatus, 64'h00AB_0000_1234_5678);
    step("R2 same-cycle ldtgt", 3, 5, 3, 64'hDEAD_BEEF_CAFE_0003, 0, 5, 3);
    peek("R3 ldtgt", 5, 3);

    // R4
    step("R4 setpc", 2, 5, 0, 64'hFFFF_FFFF_0000_1111, 0, 5, 0);
    peek("R4 setpc", 5, 3);
    check("R4 setpc literal", rdStatus, 64'h00AB_0000_0000_1111);

    // R5
    step("R5 branch", 4, 5, 3, 64'hFFFF_FFFF_FFFF_FFFF, 0, 5, 3);
    peek("R5 branch", 5, 3);
    check("R5 branch literal", rdStatus, 64'h00AB_0000_CAFE_0003);

    // R6: five pushes, first one dropped
    for (int i = 1; i <= 5; i++) step("R6 push", 5, 5, 0, 64'(i), 0, 5, 0);
    peek("R6 history", 5, 0);
    check("R6 history literal", rdStatus, 64'h00AB_2345_CAFE_0003);

    // R7: trap through T0
    step("R7 load handler", 3, 5, 0, 64'h0000_0000_0000_8000, 0, 6, 0);
    step("R2 same-cycle trap", 6, 5, 0, 64'd0, 2, 5, 0);
    peek("R7 trap swap", 5, 0);
    check("R7 status literal", rdStatus, 64'h0000_0000_0000_8000);
    check("R7 T0 literal", rdTarget, 64'h00AB_2345_CAFE_0003);

    // R8: disabled cause 2, then enabled cause 3
    step("R8 set mask", 1, 5, 0, 64'h0400_0000_0000_0042, 0, 5, 0);
    step("R8 masked trap", 6, 5, 0, 64'd0, 2, 5, 0);
    peek("R8 after masked trap", 5, 0);
    check("R8 status literal", rdStatus, 64'h0400_0000_0000_0042);
    step("R7 enabled cause", 6, 5, 0, 64'd0, 3, 5, 0);
    peek("R7 resume", 5, 0);
    check("R7 resume literal", rdStatus, 64'h00AB_2345_CAFE_0003);

    // R9: other threads untouched, idle opcodes inert
    peek("R9 thread6 untouched", 6, 3);
    step("R9 idle op7", 7, 5, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 5, 0);
    peek("R9 after idle", 5, 0);

    // Random mix over four threads
    for (int n = 0; n < 1500; n++) begin
      int op, tid, tix, cause, rt, rti;
      logic [63:0] d;
      op = int'($urandom_range(0, 7));
      tid = int'($urandom_range(0, 3));
      tix = int'($urandom_range(0, 7));
      cause = int'($urandom_range(0, 7));
      rt = int'($urandom_range(0, 3));
      rti = ($urandom_range(0, 2) == 0) ? 0 : int'($urandom_range(0, 7));
      d = {$urandom, $urandom};
      step("R9 random", op, tid, tix, d, cause, rt, rti);
    end
    for (int t = 0; t < 4; t++)
      for (int k = 0; k < 8; k++) peek("R9 final sweep", t, k);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule